// File: doc/BRIEF.md
# Output Shift Keying Amplitude Ramper

This block produces the 14-bit amplitude envelope word that scales the output of a digital synthesizer. Control registers hold a keying enable, an automatic-ramp select, a manual pin-control select, a clamped 14-bit scale factor, a 2-bit step code and a 16-bit ramp-rate field. A keying pin, assumed synchronous to the block clock, either gates the amplitude directly or starts a saturating ramp. The block also scales an incoming signed sample by the current word.

The mode comes from the control bits. With keying disabled the word sits at full scale. With keying enabled and automatic ramping off, the word follows either the programmed scale factor alone or, when pin control is set, jumps between zero and the scale factor as the pin moves. With automatic ramping on, the word moves toward the scale factor (pin high) or toward zero (pin low). It steps once per update period of four times the ramp-rate field, using a power-of-two step, and it never passes the target.

Top module: `osk_amp_ramper`

## Requirements
- R1: After reset the amplitude output is 16383 (keying off) and the ramp-rate field is 1, so automatic updates come every 4 clock cycles.
- R2: While the keying enable bit is clear, the amplitude output is 16383 (full scale) one cycle later, whatever the pin and scale factor are.
- R3: Keying enabled, automatic select clear and pin-control clear: the amplitude output equals the scale factor one cycle later and does not depend on the pin.
- R4: Keying enabled, automatic select clear and pin-control set: one cycle after the pin changes, the amplitude is the scale factor (pin high) or 0 (pin low), with no value in between.
- R5: When the automatic select bit is set, it takes priority over the pin-control bit.
- R6: In automatic mode each update moves the amplitude by 1, 2, 4 or 8 for step codes 0, 1, 2 and 3. It moves toward the scale factor when the pin is 1 and toward 0 when the pin is 0.
- R7: In automatic mode, updates come every 4*M clock cycles, where M is the ramp-rate field. A nonzero rate write restarts the period, and the first update comes 4*M cycles after the write.
- R8: An automatic update that would pass the target lands exactly on it, and the amplitude then holds there.
- R9: A ramp-rate write of 0 is rejected, and the previous rate stays in force.
- R10: A scale-factor write above 16383 stores 16383.
- R11: One cycle after it is presented, sample_out is floor(sample_in * amp_out / 2^14). Both values are taken as signed integers, with amp_out as it was in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Write strobe for the control bits |
| ctrl_key_en | input | 1 | Keying enable |
| ctrl_auto_sel | input | 1 | Automatic ramp select |
| ctrl_pin_ctl | input | 1 | Manual pin-control select |
| ctrl_step_code | input | 2 | Automatic step code (step = 1 << code) |
| scale_we | input | 1 | Write strobe for the scale factor |
| scale_in | input | 16 | Scale factor value, clamped to 14 bits |
| rate_we | input | 1 | Write strobe for the ramp-rate field |
| rate_in | input | 16 | Ramp-rate field value; 0 rejected |
| key_pin | input | 1 | Keying pin, synchronous to clk |
| sample_in | input | 16 | Signed input sample |
| amp_out | output | 14 | Current amplitude word |
| sample_out | output | 16 | Sample scaled by the amplitude word |

## Verification
The pin is toggled in each mode in turn. This separates the disabled state, which stays at full scale, from manual register mode, which ignores the pin, and from manual pin mode, which must jump to zero or to the scale factor in one cycle. In automatic mode, ramps up and down with scale factors that are not multiples of the step show the step size, the saturation at both ends, and that automatic mode wins over pin control. The spacing between amplitude changes is measured at the default rate, after a rate write and after a rejected zero write, which separates period restart from a free-running timer. Positive, negative and near-full-scale samples check the rounding of the product.

// File: rtl/osk_pkg.sv
package osk_pkg;
  typedef enum logic [1:0] {
    OSK_OFF     = 2'd0,
    OSK_MAN_REG = 2'd1,
    OSK_MAN_PIN = 2'd2,
    OSK_AUTO    = 2'd3
  } osk_mode_e;

  function automatic osk_mode_e osk_decode(input logic en, input logic auto_sel,
                                           input logic pin_ctl);
    osk_mode_e m;
    if (!en)           m = OSK_OFF;
    else if (auto_sel) m = OSK_AUTO;
    else if (pin_ctl)  m = OSK_MAN_PIN;
    else               m = OSK_MAN_REG;
    return m;
  endfunction
endpackage

// File: rtl/osk_cfg_regs.sv
module osk_cfg_regs #(
  parameter int AMP_W      = 14,
  parameter int SCALE_IN_W = 16,
  parameter int RATE_W     = 16,
  parameter int STEP_W     = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctrl_we,
  input  logic                  ctrl_key_en,
  input  logic                  ctrl_auto_sel,
  input  logic                  ctrl_pin_ctl,
  input  logic [STEP_W-1:0]     ctrl_step_code,
  input  logic                  scale_we,
  input  logic [SCALE_IN_W-1:0] scale_in,
  input  logic                  rate_we,
  input  logic [RATE_W-1:0]     rate_in,
  output logic                  en_q,
  output logic                  auto_q,
  output logic                  pinctl_q,
  output logic [STEP_W-1:0]     step_q,
  output logic [AMP_W-1:0]      scale_q,
  output logic [RATE_W-1:0]     rate_q,
  output logic                  rate_load
);
  localparam logic [AMP_W-1:0] FULL = {AMP_W{1'b1}};

  logic [AMP_W-1:0] scale_clamped;
  logic             ctrl_load;

  generate
    if (SCALE_IN_W > AMP_W) begin : g_clamp
      always_comb begin
        if (scale_in > SCALE_IN_W'(FULL)) scale_clamped = FULL;
        else                              scale_clamped = scale_in[AMP_W-1:0];
      end
    end else begin : g_noclamp
      assign scale_clamped = AMP_W'(scale_in);
    end
  endgenerate

  assign ctrl_load = ctrl_we;
  assign rate_load = rate_we && (rate_in != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      auto_q   <= 1'b0;
      pinctl_q <= 1'b0;
      step_q   <= '0;
    end else if (ctrl_load) begin
      en_q     <= ctrl_key_en;
      auto_q   <= ctrl_auto_sel;
      pinctl_q <= ctrl_pin_ctl;
      step_q   <= ctrl_step_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        scale_q <= '0;
    else if (scale_we) scale_q <= scale_clamped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rate_q <= RATE_W'(1);
    else if (rate_load) rate_q <= rate_in;
  end
endmodule

// File: rtl/osk_rate_timer.sv
module osk_rate_timer #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [RATE_W-1:0] rate_q,
  output logic              tick
);
  localparam int CNT_W = RATE_W + 2;

  logic [CNT_W-1:0] cnt_q, cnt_d, period;

  assign period = {rate_q, 2'b00};
  assign tick   = (cnt_q == period - CNT_W'(1));

  always_comb begin
    if (restart)   cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/osk_env_step.sv
module osk_env_step
  import osk_pkg::*;
#(
  parameter int AMP_W  = 14,
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  osk_mode_e         mode,
  input  logic              key_pin,
  input  logic [AMP_W-1:0]  scale_q,
  input  logic [STEP_W-1:0] step_q,
  input  logic              tick,
  output logic [AMP_W-1:0]  amp_q
);
  localparam logic [AMP_W-1:0] FULL = {AMP_W{1'b1}};

  logic [AMP_W-1:0] amp_d, target, step_amt, gap_up, gap_dn;

  assign step_amt = AMP_W'(1) << step_q;
  assign target   = key_pin ? scale_q : '0;
  assign gap_up   = target - amp_q;
  assign gap_dn   = amp_q - target;

  always_comb begin
    amp_d = amp_q;
    unique case (mode)
      OSK_OFF:     amp_d = FULL;
      OSK_MAN_REG: amp_d = scale_q;
      OSK_MAN_PIN: amp_d = target;
      OSK_AUTO: begin
        if (tick) begin
          if (amp_q < target)
            amp_d = (gap_up > step_amt) ? amp_q + step_amt : target;
          else if (amp_q > target)
            amp_d = (gap_dn > step_amt) ? amp_q - step_amt : target;
        end
      end
      default:     amp_d = FULL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) amp_q <= FULL;
    else        amp_q <= amp_d;
  end
endmodule

// File: rtl/osk_gain_mul.sv
module osk_gain_mul #(
  parameter int SAMPLE_W = 16,
  parameter int AMP_W    = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic [AMP_W-1:0]    amp,
  output logic [SAMPLE_W-1:0] sample_out
);
  localparam int PROD_W = SAMPLE_W + AMP_W + 1;

  logic signed [PROD_W-1:0] prod;
  logic        [SAMPLE_W-1:0] scaled;

  assign prod   = $signed(sample_in) * $signed({1'b0, amp});
  assign scaled = prod[AMP_W +: SAMPLE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_out <= '0;
    else        sample_out <= scaled;
  end
endmodule

// File: rtl/osk_amp_ramper.sv
module osk_amp_ramper
  import osk_pkg::*;
#(
  parameter int AMP_W      = 14,
  parameter int SCALE_IN_W = 16,
  parameter int RATE_W     = 16,
  parameter int STEP_W     = 2,
  parameter int SAMPLE_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctrl_we,
  input  logic                  ctrl_key_en,
  input  logic                  ctrl_auto_sel,
  input  logic                  ctrl_pin_ctl,
  input  logic [STEP_W-1:0]     ctrl_step_code,
  input  logic                  scale_we,
  input  logic [SCALE_IN_W-1:0] scale_in,
  input  logic                  rate_we,
  input  logic [RATE_W-1:0]     rate_in,
  input  logic                  key_pin,
  input  logic [SAMPLE_W-1:0]   sample_in,
  output logic [AMP_W-1:0]      amp_out,
  output logic [SAMPLE_W-1:0]   sample_out
);
  logic [1:0]        rst_pipe;
  logic              rst_n_s;
  logic              en_q, auto_q, pinctl_q, rate_load, tick;
  logic [STEP_W-1:0] step_q;
  logic [AMP_W-1:0]  scale_q;
  logic [RATE_W-1:0] rate_q;
  osk_mode_e         mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  osk_cfg_regs #(
    .AMP_W(AMP_W), .SCALE_IN_W(SCALE_IN_W), .RATE_W(RATE_W), .STEP_W(STEP_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n_s),
    .ctrl_we(ctrl_we), .ctrl_key_en(ctrl_key_en), .ctrl_auto_sel(ctrl_auto_sel),
    .ctrl_pin_ctl(ctrl_pin_ctl), .ctrl_step_code(ctrl_step_code),
    .scale_we(scale_we), .scale_in(scale_in),
    .rate_we(rate_we), .rate_in(rate_in),
    .en_q(en_q), .auto_q(auto_q), .pinctl_q(pinctl_q), .step_q(step_q),
    .scale_q(scale_q), .rate_q(rate_q), .rate_load(rate_load)
  );

  assign mode = osk_decode(en_q, auto_q, pinctl_q);

  osk_rate_timer #(.RATE_W(RATE_W)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .restart(rate_load), .rate_q(rate_q), .tick(tick)
  );

  osk_env_step #(.AMP_W(AMP_W), .STEP_W(STEP_W)) u_env (
    .clk(clk), .rst_n(rst_n_s), .mode(mode), .key_pin(key_pin),
    .scale_q(scale_q), .step_q(step_q), .tick(tick), .amp_q(amp_out)
  );

  osk_gain_mul #(.SAMPLE_W(SAMPLE_W), .AMP_W(AMP_W)) u_mul (
    .clk(clk), .rst_n(rst_n_s), .sample_in(sample_in), .amp(amp_out),
    .sample_out(sample_out)
  );
endmodule

// File: rtl/osk_amp_ramper_chk.sv
module osk_amp_ramper_chk
  import osk_pkg::*;
#(
  parameter int AMP_W      = 14,
  parameter int SCALE_IN_W = 16,
  parameter int RATE_W     = 16
) (
  input logic                  clk,
  input logic                  rst_n_s,
  input osk_mode_e             mode,
  input logic                  key_pin,
  input logic                  tick,
  input logic                  scale_we,
  input logic [SCALE_IN_W-1:0] scale_in,
  input logic [AMP_W-1:0]      scale_q,
  input logic                  rate_we,
  input logic [RATE_W-1:0]     rate_in,
  input logic [RATE_W-1:0]     rate_q,
  input logic                  rate_load,
  input logic [AMP_W-1:0]      amp_out
);
  localparam logic [AMP_W-1:0] FULL = {AMP_W{1'b1}};

  // R2
  off_full_scale_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode == OSK_OFF) |=> (amp_out == FULL));

  // R3
  man_reg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode == OSK_MAN_REG) |=> (amp_out == $past(scale_q)));

  // R4
  man_pin_jump_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode == OSK_MAN_PIN) |=> (amp_out == ($past(key_pin) ? $past(scale_q) : '0)));

  // R7
  auto_hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode == OSK_AUTO && !tick) |=> $stable(amp_out));

  // R7
  restart_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rate_load |=> !tick);

  // R8
  auto_no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode == OSK_AUTO && tick && key_pin && amp_out <= scale_q)
      |=> (amp_out <= $past(scale_q)) && (amp_out >= $past(amp_out)));

  // R9
  zero_rate_reject_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rate_we && rate_in == '0) |=> $stable(rate_q));

  // R10
  scale_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (scale_we && scale_in > SCALE_IN_W'(FULL)) |=> (scale_q == FULL));
endmodule

bind osk_amp_ramper osk_amp_ramper_chk #(
  .AMP_W(AMP_W), .SCALE_IN_W(SCALE_IN_W), .RATE_W(RATE_W)
) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .mode(mode), .key_pin(key_pin), .tick(tick),
  .scale_we(scale_we), .scale_in(scale_in), .scale_q(scale_q),
  .rate_we(rate_we), .rate_in(rate_in), .rate_q(rate_q), .rate_load(rate_load),
  .amp_out(amp_out)
);

// File: tb/osk_amp_ramper_bench.sv
module osk_amp_ramper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0, ctrl_key_en = 1'b0, ctrl_auto_sel = 1'b0, ctrl_pin_ctl = 1'b0;
  logic [1:0]  ctrl_step_code = '0;
  logic        scale_we = 1'b0, rate_we = 1'b0, key_pin = 1'b0;
  logic [15:0] scale_in = '0, rate_in = '0, sample_in = '0;
  logic [13:0] amp_out;
  logic [15:0] sample_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  osk_amp_ramper u_osk_amp_ramper (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_key_en(ctrl_key_en),
    .ctrl_auto_sel(ctrl_auto_sel), .ctrl_pin_ctl(ctrl_pin_ctl),
    .ctrl_step_code(ctrl_step_code), .scale_we(scale_we), .scale_in(scale_in),
    .rate_we(rate_we), .rate_in(rate_in), .key_pin(key_pin), .sample_in(sample_in),
    .amp_out(amp_out), .sample_out(sample_out)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input bit en, input bit au, input bit pc, input int code);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_key_en = en; ctrl_auto_sel = au; ctrl_pin_ctl = pc;
    ctrl_step_code = code[1:0];
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic write_scale(input int v);
    @(negedge clk);
    scale_we = 1'b1; scale_in = v[15:0];
    @(negedge clk);
    scale_we = 1'b0;
  endtask

  task automatic write_rate(input int v);
    @(negedge clk);
    rate_we = 1'b1; rate_in = v[15:0];
    @(negedge clk);
    rate_we = 1'b0;
  endtask

  task automatic wait_change(output int n, output int v);
    int prev;
    prev = amp_out;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (amp_out == prev && n < 3000);
    v = amp_out;
  endtask

  task automatic test_reset();
    check("R1 reset amplitude", amp_out, 16383);
  endtask

  task automatic test_disabled();
    write_scale(100);
    key_pin = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R2 disabled pin high", amp_out, 16383);
    key_pin = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R2 disabled pin low", amp_out, 16383);
  endtask

  task automatic test_manual_reg();
    write_scale(5000);
    write_ctrl(1, 0, 0, 0);
    @(negedge clk);
    check("R3 manual register amplitude", amp_out, 5000);
    key_pin = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R3 pin ignored high", amp_out, 5000);
    key_pin = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R3 pin ignored low", amp_out, 5000);
  endtask

  task automatic test_manual_pin();
    write_ctrl(1, 0, 1, 0);
    @(negedge clk);
    check("R4 pin low gives zero", amp_out, 0);
    key_pin = 1'b1;
    @(negedge clk);
    check("R4 pin high jumps to scale", amp_out, 5000);
    key_pin = 1'b0;
    @(negedge clk);
    check("R4 pin low jumps to zero", amp_out, 0);
  endtask

  task automatic test_clamp();
    write_ctrl(1, 0, 0, 0);
    write_scale(20000);
    @(negedge clk);
    check("R10 clamp 20000", amp_out, 16383);
    write_scale(16384);
    @(negedge clk);
    check("R10 clamp 16384", amp_out, 16383);
    write_scale(16382);
    @(negedge clk);
    check("R10 in range kept", amp_out, 16382);
  endtask

  task automatic one_sample(input int s, input int a);
    longint exp;
    write_scale(a);
    @(negedge clk);
    sample_in = s[15:0];
    @(negedge clk);
    exp = (longint'(s) * longint'(amp_out)) >>> 14;
    check("R11 scaled sample", longint'($signed(sample_out)), exp);
  endtask

  task automatic test_multiply();
    one_sample(1000, 8192);
    one_sample(-1001, 8192);
    one_sample(32767, 16383);
    one_sample(-32768, 16383);
    one_sample(12345, 0);
  endtask

  task automatic test_auto_default();
    int n, v;
    write_ctrl(1, 0, 1, 0);
    key_pin = 1'b0;
    write_scale(10);
    @(negedge clk);
    write_ctrl(1, 1, 1, 2);
    repeat (8) @(negedge clk);
    check("R6 auto start at zero", amp_out, 0);
    key_pin = 1'b1;
    wait_change(n, v);
    check("R5 auto wins over pin control, first step", v, 4);
    wait_change(n, v);
    check("R7 default period cycles", n, 4);
    check("R6 step code 2 second step", v, 8);
    wait_change(n, v);
    check("R7 default period cycles again", n, 4);
    check("R8 saturate at scale", v, 10);
    repeat (20) @(negedge clk);
    check("R8 hold at scale", amp_out, 10);
    key_pin = 1'b0;
    wait_change(n, v);
    check("R6 ramp down step", v, 6);
    wait_change(n, v);
    check("R6 ramp down step 2", v, 2);
    wait_change(n, v);
    check("R8 saturate at zero", v, 0);
    repeat (20) @(negedge clk);
    check("R8 hold at zero", amp_out, 0);
  endtask

  task automatic test_auto_rate();
    int n, v, a0;
    write_scale(1000);
    write_ctrl(1, 1, 0, 3);
    key_pin = 1'b1;
    write_rate(3);
    a0 = amp_out;
    wait_change(n, v);
    check("R7 first update after rate write", n, 12);
    check("R6 step code 3", v - a0, 8);
    a0 = v;
    wait_change(n, v);
    check("R7 period of 12", n, 12);
    write_rate(0);
    wait_change(n, v);
    a0 = v;
    wait_change(n, v);
    check("R9 zero rate rejected", n, 12);
    write_ctrl(1, 1, 0, 0);
    wait_change(n, v);
    a0 = v;
    wait_change(n, v);
    check("R6 step code 0", v - a0, 1);
    write_ctrl(1, 1, 0, 1);
    wait_change(n, v);
    a0 = v;
    wait_change(n, v);
    check("R6 step code 1", v - a0, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_disabled();
    test_manual_reg();
    test_manual_pin();
    test_clamp();
    test_multiply();
    test_auto_default();
    test_auto_rate();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule